// File: doc/BRIEF.md
# Word-Serial Radix-2 Montgomery Multiplier

This block forms the Montgomery product of two operands modulo an odd modulus. It returns a value congruent to X·Y·2^(-N) mod M, where N is the full operand width (word width W times word count E). The multiplier X is consumed one bit per outer pass, least significant bit first. For each bit, the multiplicand Y, the modulus M and the running partial sum S are swept word by word, from word 0 to word E-1, through a single W-bit carry-propagate word adder. Because of this, one narrow datapath serves any precision that the two parameters select.

Operands are presented in parallel and taken in by a one-cycle start strobe. `busy` stays high for the whole computation. After that, `done` rises and holds the result until the next accepted start. No final subtraction of M is applied. The operand limits (M odd and below 2^(N-2), X and Y below 2M) keep the result below 2M, so it can be fed straight into another multiplication.

Top module: `mont_mul_ws`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is all zeros.
- R2: For odd M < 2^(N-2) and X, Y < 2M, the final `result` is congruent modulo M to X·Y·2^(-N).
- R3: Under the same operand limits the final `result` is strictly below 2M, with no correction step.
- R4: A start seen while idle sets `busy` from the next cycle. `done` rises exactly N·(E+1) clock cycles after the accepting edge, which is E+1 cycles for each bit of X.
- R5: A `start` pulse while `busy` is high is ignored. The running computation neither restarts nor changes its timing or result.
- R6: Once set, `done` stays high and `result` stays unchanged until the next accepted start. `done` and `busy` are never high together.
- R7: With X = 0 the result is exactly zero.
- R8: Operands are captured on the accepting edge. Later changes on `x_in`, `y_in` and `m_in` have no effect on the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, accepted only while not busy |
| x_in | input | N | Multiplier operand, scanned bit by bit |
| y_in | input | N | Multiplicand operand |
| m_in | input | N | Odd modulus |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Result valid, held until next start |
| result | output | N | Montgomery product, below 2M |

## Verification
The only timed output is the end of the run. The bench counts rising edges from the edge that accepts start. It expects `busy` at the first falling edge after that edge, and `done` at the falling edge that follows edge N·(E+1), which is 160 cycles with the default parameters. All outputs are sampled on falling edges, so each comparison falls half a cycle after the register that produced it has updated. A checker counter repeats the same cycle count from inside the block, and it also watches that the word-0 step always clears the low bit and that the final carry never exceeds one.

// File: rtl/mmw_pkg.sv
package mmw_pkg;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  // Reduction bit: makes the low bit of S + xi*Y + q*M even (M odd).
  function automatic logic red_bit(input logic s0, input logic xi, input logic y0);
    return s0 ^ (xi & y0);
  endfunction

endpackage

// File: rtl/mmw_word_pe.sv
module mmw_word_pe #(
  parameter int W = 8
) (
  input  logic [W-1:0] s_w,
  input  logic [W-1:0] y_w,
  input  logic [W-1:0] m_w,
  input  logic         xi,
  input  logic         q,
  input  logic [1:0]   cin,
  output logic [W-1:0] sum_lo,
  output logic [1:0]   cout
);

  localparam int SW = W + 2;

  // One word of S + xi*Y + q*M + carry, carry-propagate form.
  function automatic logic [SW-1:0] word_sum(
    input logic [W-1:0] s, input logic [W-1:0] y, input logic [W-1:0] m,
    input logic a, input logic b, input logic [1:0] c);
    logic [SW-1:0] acc;
    acc = {2'b00, s};
    if (a) acc = acc + {2'b00, y};
    if (b) acc = acc + {2'b00, m};
    acc = acc + {{W{1'b0}}, c};
    return acc;
  endfunction

  logic [SW-1:0] tot;

  always_comb begin
    tot    = word_sum(s_w, y_w, m_w, xi, q, cin);
    sum_lo = tot[W-1:0];
    cout   = tot[SW-1:W];
  end

endmodule

// File: rtl/mmw_ctrl.sv
module mmw_ctrl #(
  parameter int E   = 4,
  parameter int NXB = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic load,
  output logic first_step,
  output logic top_step,
  output logic [$clog2(E+1)-1:0] word_idx
);

  import mmw_pkg::*;

  localparam int WD = $clog2(E + 1);
  localparam int BD = (NXB > 1) ? $clog2(NXB) : 1;
  localparam logic [WD-1:0] WLAST = WD'(E);
  localparam logic [BD-1:0] BLAST = BD'(NXB - 1);

  phase_t          ph_q;
  logic [BD-1:0]   bit_q;
  logic [WD-1:0]   word_q;
  logic            done_q;
  logic            last_pass;

  assign busy       = (ph_q == PH_RUN);
  assign done       = done_q;
  assign load       = start && !busy;
  assign word_idx   = word_q;
  assign first_step = busy && (word_q == '0);
  assign top_step   = busy && (word_q == WLAST);
  assign last_pass  = (bit_q == BLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
      bit_q  <= '0;
      word_q <= '0;
    end else if (load) begin
      ph_q   <= PH_RUN;
      done_q <= 1'b0;
      bit_q  <= '0;
      word_q <= '0;
    end else if (busy) begin
      if (word_q == WLAST) begin
        word_q <= '0;
        if (last_pass) begin
          ph_q   <= PH_IDLE;
          done_q <= 1'b1;
        end else begin
          bit_q <= bit_q + BD'(1);
        end
      end else begin
        word_q <= word_q + WD'(1);
      end
    end
  end

endmodule

// File: rtl/mmw_sum_store.sv
module mmw_sum_store #(
  parameter int W  = 8,
  parameter int E  = 4,
  parameter int ID = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  logic [ID-1:0]   wr_idx,
  input  logic [W-1:0]    wr_data,
  input  logic [ID-1:0]   rd_idx,
  output logic [W-1:0]    rd_word,
  output logic [W*E-1:0]  flat
);

  logic [W-1:0] s_q [E];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < E; k++) s_q[k] <= '0;
    end else if (clr) begin
      for (int k = 0; k < E; k++) s_q[k] <= '0;
    end else if (wr_en) begin
      s_q[wr_idx] <= wr_data;
    end
  end

  assign rd_word = s_q[rd_idx];

  genvar g;
  generate
    for (g = 0; g < E; g++) begin : g_flat
      assign flat[g*W +: W] = s_q[g];
    end
  endgenerate

endmodule

// File: rtl/mont_mul_ws.sv
module mont_mul_ws #(
  parameter int W = 8,
  parameter int E = 4,
  localparam int N = W * E
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] x_in,
  input  logic [N-1:0] y_in,
  input  logic [N-1:0] m_in,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] result
);

  localparam int WD  = $clog2(E + 1);
  localparam int ID  = (E > 1) ? $clog2(E) : 1;
  localparam int LAT = N * (E + 1);

  // control
  logic          load;
  logic          first_step;
  logic          top_step;
  logic [WD-1:0] word_idx;

  mmw_ctrl #(.E(E), .NXB(N)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .load       (load),
    .first_step (first_step),
    .top_step   (top_step),
    .word_idx   (word_idx)
  );

  // operand registers
  logic [N-1:0] x_sh;
  logic [N-1:0] y_q;
  logic [N-1:0] m_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_sh <= '0;
      y_q  <= '0;
      m_q  <= '0;
    end else if (load) begin
      x_sh <= x_in;
      y_q  <= y_in;
      m_q  <= m_in;
    end else if (top_step) begin
      x_sh <= x_sh >> 1;
    end
  end

  logic [W-1:0] y_w [E];
  logic [W-1:0] m_w [E];

  genvar g;
  generate
    for (g = 0; g < E; g++) begin : g_words
      assign y_w[g] = y_q[g*W +: W];
      assign m_w[g] = m_q[g*W +: W];
    end
  endgenerate

  // word selection
  logic [ID-1:0] rd_idx;
  logic [ID-1:0] wr_idx;
  logic          wr_en;
  logic [W-1:0]  wr_data;
  logic [W-1:0]  s_rd;

  assign rd_idx = (word_idx < WD'(E)) ? word_idx[ID-1:0] : '0;
  assign wr_idx = top_step ? ID'(E - 1) : ID'(word_idx - WD'(1));
  assign wr_en  = busy && (word_idx != '0);

  // word processing element
  logic         xi;
  logic         q_cur;
  logic         q_q;
  logic [1:0]   cin;
  logic [1:0]   carry_q;
  logic [W-1:0] pe_sum;
  logic [1:0]   pe_cout;
  logic [W-2:0] pend_q;

  assign xi    = x_sh[0];
  assign q_cur = first_step ? mmw_pkg::red_bit(s_rd[0], xi, y_w[0][0]) : q_q;
  assign cin   = first_step ? 2'b00 : carry_q;

  mmw_word_pe #(.W(W)) u_pe (
    .s_w    (s_rd),
    .y_w    (y_w[rd_idx]),
    .m_w    (m_w[rd_idx]),
    .xi     (xi),
    .q      (q_cur),
    .cin    (cin),
    .sum_lo (pe_sum),
    .cout   (pe_cout)
  );

  // shifted write-back: new MSB of word j-1 comes from LSB of word j
  assign wr_data = top_step ? {carry_q[0], pend_q} : {pe_sum[0], pend_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q     <= 1'b0;
      carry_q <= 2'b00;
      pend_q  <= '0;
    end else if (busy && !top_step) begin
      if (first_step) q_q <= q_cur;
      carry_q <= pe_cout;
      pend_q  <= pe_sum[W-1:1];
    end
  end

  mmw_sum_store #(.W(W), .E(E), .ID(ID)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (load),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_word (s_rd),
    .flat    (result)
  );

  // named events for the checker
  logic ev_first_lsb;
  logic ev_top_carry_hi;
  assign ev_first_lsb    = pe_sum[0];
  assign ev_top_carry_hi = carry_q[1];

endmodule

// File: rtl/mont_mul_ws_chk.sv
module mont_mul_ws_chk #(
  parameter int N   = 32,
  parameter int LAT = 160
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] result,
  input logic         first_step,
  input logic         top_step,
  input logic         ev_first_lsb,
  input logic         ev_top_carry_hi
);

  localparam int CW = $clog2(LAT + 2);

  logic [CW-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lat_cnt <= '0;
    else if (start && !busy) lat_cnt <= '0;
    else if (busy)           lat_cnt <= lat_cnt + CW'(1);
  end

  p_busy_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (lat_cnt == CW'(LAT)));

  p_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result)));

  p_lsb_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    first_step |-> !ev_first_lsb);

  p_top_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    top_step |-> !ev_top_carry_hi);

endmodule

bind mont_mul_ws mont_mul_ws_chk #(.N(N), .LAT(LAT)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start           (start),
  .busy            (busy),
  .done            (done),
  .result          (result),
  .first_step      (first_step),
  .top_step        (top_step),
  .ev_first_lsb    (ev_first_lsb),
  .ev_top_carry_hi (ev_top_carry_hi)
);

// File: tb/mont_mul_ws_tb.sv
module mont_mul_ws_tb;

  localparam int W   = 8;
  localparam int E   = 4;
  localparam int N   = W * E;
  localparam int LAT = N * (E + 1);
  localparam int NV  = 8;

  // {x, y, m}
  localparam logic [3*N-1:0] VEC [NV] = '{
    {32'h1234_5678, 32'h3FFF_FFFE, 32'h3FFF_FFFF},
    {32'h0000_0000, 32'h2ABC_DEF1, 32'h3FFF_FFFF},
    {32'h1A2B_3C4D, 32'h0F0F_0F0F, 32'h2F1E_0D3B},
    {32'h0000_0005, 32'h0000_000D, 32'h0000_0007},
    {32'h1FFF_FFFF, 32'h1FFF_FFFF, 32'h1000_0001},
    {32'h0000_0001, 32'h3A5A_5A5A, 32'h3A5A_5A5B},
    {32'h0000_0005, 32'h0000_0004, 32'h0000_0003},
    {32'h7FFF_FFFD, 32'h7FFF_FFFD, 32'h3FFF_FFFF}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] x_in = '0;
  logic [N-1:0] y_in = '0;
  logic [N-1:0] m_in = '0;
  logic         busy;
  logic         done;
  logic [N-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mont_mul_ws #(.W(W), .E(E)) u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .x_in   (x_in),
    .y_in   (y_in),
    .m_in   (m_in),
    .busy   (busy),
    .done   (done),
    .result (result)
  );

  // X*Y*2^-N mod M: reduce the product, then halve N times modulo M.
  function automatic longint unsigned ref_mont(longint unsigned x,
      longint unsigned y, longint unsigned m);
    longint unsigned r;
    r = (x * y) % m;
    for (int i = 0; i < N; i++) r = r[0] ? (r + m) >> 1 : r >> 1;
    return r;
  endfunction

  task automatic check(input string req, input bit ok,
      input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Pulse start at a falling edge, optionally disturb the inputs mid-run.
  task automatic run(input logic [N-1:0] x, input logic [N-1:0] y,
      input logic [N-1:0] m, input bit disturb, output int cyc);
    int edges;
    x_in = x; y_in = y; m_in = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    check("R4 busy", busy === 1'b1, busy, 1);
    while (edges < LAT + 40) begin
      @(negedge clk);
      edges++;
      if (disturb && edges == 20) begin
        start = 1'b1; x_in = 32'h0000_0003; y_in = 32'h0000_0005; m_in = 32'h0000_0007;
      end
      if (disturb && edges == 21) start = 1'b0;
      if (done) break;
    end
    cyc = edges - 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    longint unsigned xv, yv, mv, ev, rv;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", busy === 1'b0, busy, 0);
    check("R1 done", done === 1'b0, done, 0);
    check("R1 result", result === '0, result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      xv = VEC[v][3*N-1:2*N];
      yv = VEC[v][2*N-1:N];
      mv = VEC[v][N-1:0];
      run(VEC[v][3*N-1:2*N], VEC[v][2*N-1:N], VEC[v][N-1:0], 1'b0, cyc);
      ev = ref_mont(xv, yv, mv);
      rv = result;
      check("R4 latency", cyc == LAT, cyc, LAT);
      check("R2 congruence", (rv % mv) == ev, rv % mv, ev);
      check("R3 bound", rv < 2 * mv, rv, 2 * mv);
      if (xv == 0) check("R7 zero", rv == 0, rv, 0);
    end

    // R5, R8: start pulse and new operands while busy
    xv = VEC[2][3*N-1:2*N];
    yv = VEC[2][2*N-1:N];
    mv = VEC[2][N-1:0];
    run(VEC[2][3*N-1:2*N], VEC[2][2*N-1:N], VEC[2][N-1:0], 1'b1, cyc);
    ev = ref_mont(xv, yv, mv);
    rv = result;
    check("R5 no restart", cyc == LAT, cyc, LAT);
    check("R8 operands held", (rv % mv) == ev, rv % mv, ev);

    // R6: done and result hold while idle with moving inputs
    for (int k = 0; k < 6; k++) begin
      x_in = x_in + 32'd17; y_in = y_in ^ 32'h55;
      @(negedge clk);
    end
    check("R6 done held", done === 1'b1, done, 1);
    check("R6 not busy", busy === 1'b0, busy, 0);
    check("R6 result held", result == rv, result, rv);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule